// File: doc/BRIEF.md
# Debug Status Register Access-Trap Resolver

This block decides the result of a software read of a 64-bit debug-channel status register. For each read request it takes the current privilege level (0 to 3), the set of optional features and privilege levels that are present, and the trap-control bits held at levels 1, 2 and 3. It gives exactly one result: the read completes and returns the register value, the read raises an undefined-instruction exception, or the read traps to level 1, 2 or 3 with a fixed syndrome class.

The order of the checks depends on the privilege level. The undefined and trap conditions are tested in a strict priority order. A general trap enable at level 2 can redirect a level-1 trap to level 2. The block also builds the read value from the receive-full and transmit-full flags of the channel. The request strobe and all results are registered, so each result appears as a single-cycle valid pulse one clock after its request.

Top module: `dcsr_access_resolver`

## Requirements
- R1: While reset is asserted (active-low, synchronous), and on the first cycle after it, valid_o, read_ok_o, undef_o, trap_o, trap_lvl_o, trap_ec_o and rdata_o are all zero.
- R2: A request sampled at a clock edge produces valid_o high for one cycle, starting on that edge. With no request, valid_o and all three result flags stay low. Requests on back-to-back cycles give back-to-back valid pulses.
- R3: Whenever valid_o is high, exactly one of read_ok_o, undef_o and trap_o is high. Whenever valid_o is low, none of them is high.
- R4: On a read, rdata_o bit 30 equals rx_full_i and bit 29 equals tx_full_i, and every other bit is zero. When read_ok_o is low, rdata_o is all zero.
- R5: When the 64-bit execution feature is absent (feat_a64_i = 0), the result is undefined at every level. This check overrides every other input.
- R6: When the core is halted and the ignore-traps option is set, the read completes and no trap or undefined check is made.
- R7: At level 3 (cur_el_i = 2'd3), the read always completes.
- R8: At levels 0 to 2, with level 3 present and the undefined-priority indication set, the level-3 comms-trap bit (only when fine-grained traps are present) and then the level-3 debug-access bit give undefined. These two checks come before all level-1 and level-2 checks.
- R9: At level 0 only, the next check is the level-1 comms-trap bit. It traps to level 2 when level 2 is enabled and the general trap enable is set. Otherwise it traps to level 1. It comes before the level-2 checks.
- R10: At levels 0 and 1, with level 2 enabled, the next checks trap to level 2: the level-2 comms-trap bit (only when fine-grained traps are present), then either of the two level-2 debug trap bits being nonzero, then (at level 0 only) the general trap enable. These checks do not apply at level 2 or when level 2 is disabled.
- R11: The last checks at levels 0 to 2 are the level-3 comms-trap bit (only when fine-grained traps are present) and then the level-3 debug-access bit. Each one gives undefined when the secure-debug-disabled indication is set, and a trap to level 3 otherwise. When no check fires, the read completes.
- R12: Every check that involves level 3 is skipped when level 3 is not implemented. Every comms-trap bit is ignored when fine-grained traps are absent.
- R13: A trap reports trap_ec_o = 6'h18 and a trap_lvl_o of 1, 2 or 3. When there is no trap, trap_lvl_o and trap_ec_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| cur_el_i | input | 2 | Current privilege level, 0 to 3 |
| feat_a64_i | input | 1 | 64-bit execution feature present |
| feat_fgt_i | input | 1 | Fine-grained traps present |
| lvl2_en_i | input | 1 | Level 2 enabled |
| has_lvl3_i | input | 1 | Level 3 implemented |
| halted_i | input | 1 | Core halted in debug state |
| ign_trap_i | input | 1 | Implementation option: ignore traps while halted |
| l3_undef_prio_i | input | 1 | Level-3 undefined-has-priority indication |
| l3_sec_dbg_dis_i | input | 1 | Level-3 secure-debug-disabled indication |
| l3_comm_trap_i | input | 1 | Level-3 comms-trap bit |
| l3_dbg_trap_i | input | 1 | Level-3 debug-access trap bit |
| l2_comm_trap_i | input | 1 | Level-2 comms-trap bit |
| l2_dbg_trap_i | input | 2 | Level-2 debug trap bits |
| l2_gen_trap_i | input | 1 | Level-2 general trap enable |
| l1_comm_trap_i | input | 1 | Level-1 comms-trap bit |
| rx_full_i | input | 1 | Receive data register full flag |
| tx_full_i | input | 1 | Transmit data register full flag |
| valid_o | output | 1 | Result valid pulse |
| read_ok_o | output | 1 | Read completes with rdata_o |
| undef_o | output | 1 | Undefined-instruction result |
| trap_o | output | 1 | Trap result |
| trap_lvl_o | output | 2 | Trap target level |
| trap_ec_o | output | 6 | Trap syndrome class |
| rdata_o | output | 64 | Read value |

## Verification
The bench builds the block with its default parameters: a 64-bit value, the receive flag at bit 30, the transmit flag at bit 29 and class 0x18. With these values the exact bit positions and the syndrome code can be checked against fixed numbers. The vectors set many trap bits at the same time, so each one shows which check wins. They cover every privilege level, including the lower-priority bits that a winning check must hide and the presence inputs that switch whole groups of checks off.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;

    typedef enum logic [1:0] {
        OUT_READ  = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_TRAP  = 2'd2
    } outcome_e;

    typedef struct packed {
        logic       feat_a64;
        logic       feat_fgt;
        logic       lvl2_en;
        logic       has_lvl3;
        logic       halted;
        logic       ign_trap;
        logic       l3_undef_prio;
        logic       l3_sec_dbg_dis;
        logic       l3_comm;
        logic       l3_dbg;
        logic       l2_comm;
        logic [1:0] l2_dbg;
        logic       l2_gen;
        logic       l1_comm;
    } ctrl_t;

    typedef struct packed {
        outcome_e   kind;
        logic [1:0] lvl;
    } decision_t;

endpackage

// File: rtl/dcsr_lvl3_gate.sv
module dcsr_lvl3_gate
    import dcsr_pkg::*;
(
    input  ctrl_t ctrl_i,
    output logic  early_undef_o,
    output logic  late_hit_o,
    output logic  late_undef_o
);
    logic comm_hit;
    logic any_hit;

    always_comb begin
        comm_hit      = ctrl_i.has_lvl3 && ctrl_i.feat_fgt && ctrl_i.l3_comm;
        any_hit       = comm_hit || (ctrl_i.has_lvl3 && ctrl_i.l3_dbg);
        early_undef_o = ctrl_i.l3_undef_prio && any_hit;
        late_hit_o    = any_hit;
        late_undef_o  = any_hit && ctrl_i.l3_sec_dbg_dis;
    end
endmodule

// File: rtl/dcsr_trap_resolver.sv
module dcsr_trap_resolver
    import dcsr_pkg::*;
(
    input  logic [1:0] el_i,
    input  ctrl_t      ctrl_i,
    output decision_t  dec_o
);
    logic early_undef;
    logic late_hit;
    logic late_undef;
    logic at_el0;
    logic low_el;
    logic l2_hit;

    dcsr_lvl3_gate u_lvl3_gate (
        .ctrl_i       (ctrl_i),
        .early_undef_o(early_undef),
        .late_hit_o   (late_hit),
        .late_undef_o (late_undef)
    );

    always_comb begin
        at_el0 = (el_i == 2'd0);
        low_el = (el_i == 2'd0) || (el_i == 2'd1);
        l2_hit = low_el && ctrl_i.lvl2_en &&
                 ((ctrl_i.feat_fgt && ctrl_i.l2_comm) ||
                  (ctrl_i.l2_dbg != 2'b00) ||
                  (at_el0 && ctrl_i.l2_gen));

        dec_o.kind = OUT_READ;
        dec_o.lvl  = 2'd0;

        if (!ctrl_i.feat_a64) begin
            dec_o.kind = OUT_UNDEF;
        end else if (ctrl_i.halted && ctrl_i.ign_trap) begin
            dec_o.kind = OUT_READ;
        end else if (el_i == 2'd3) begin
            dec_o.kind = OUT_READ;
        end else if (early_undef) begin
            dec_o.kind = OUT_UNDEF;
        end else if (at_el0 && ctrl_i.feat_fgt && ctrl_i.l1_comm) begin
            dec_o.kind = OUT_TRAP;
            dec_o.lvl  = (ctrl_i.lvl2_en && ctrl_i.l2_gen) ? 2'd2 : 2'd1;
        end else if (l2_hit) begin
            dec_o.kind = OUT_TRAP;
            dec_o.lvl  = 2'd2;
        end else if (late_hit) begin
            if (late_undef) begin
                dec_o.kind = OUT_UNDEF;
            end else begin
                dec_o.kind = OUT_TRAP;
                dec_o.lvl  = 2'd3;
            end
        end
    end
endmodule

// File: rtl/dcsr_value_builder.sv
module dcsr_value_builder #(
    parameter int DATA_W = 64,
    parameter int RX_POS = 30,
    parameter int TX_POS = 29
) (
    input  logic              rx_full_i,
    input  logic              tx_full_i,
    input  logic              enable_i,
    output logic [DATA_W-1:0] value_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == RX_POS) begin : g_rx
            assign value_o[b] = enable_i & rx_full_i;
        end else if (b == TX_POS) begin : g_tx
            assign value_o[b] = enable_i & tx_full_i;
        end else begin : g_zero
            assign value_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/dcsr_access_resolver.sv
module dcsr_access_resolver
    import dcsr_pkg::*;
#(
    parameter int          DATA_W  = 64,
    parameter int          RX_POS  = 30,
    parameter int          TX_POS  = 29,
    parameter int          EC_W    = 6,
    parameter logic [5:0]  TRAP_EC = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        cur_el_i,
    input  logic              feat_a64_i,
    input  logic              feat_fgt_i,
    input  logic              lvl2_en_i,
    input  logic              has_lvl3_i,
    input  logic              halted_i,
    input  logic              ign_trap_i,
    input  logic              l3_undef_prio_i,
    input  logic              l3_sec_dbg_dis_i,
    input  logic              l3_comm_trap_i,
    input  logic              l3_dbg_trap_i,
    input  logic              l2_comm_trap_i,
    input  logic [1:0]        l2_dbg_trap_i,
    input  logic              l2_gen_trap_i,
    input  logic              l1_comm_trap_i,
    input  logic              rx_full_i,
    input  logic              tx_full_i,
    output logic              valid_o,
    output logic              read_ok_o,
    output logic              undef_o,
    output logic              trap_o,
    output logic [1:0]        trap_lvl_o,
    output logic [EC_W-1:0]   trap_ec_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [EC_W-1:0] EC_CODE = EC_W'(TRAP_EC);

    typedef struct packed {
        logic              valid;
        logic              read_ok;
        logic              undef;
        logic              trap;
        logic [1:0]        lvl;
        logic [EC_W-1:0]   ec;
        logic [DATA_W-1:0] data;
    } out_t;

    ctrl_t             ctrl;
    decision_t         dec;
    logic              is_read;
    logic [DATA_W-1:0] value;
    out_t              out_d;
    out_t              out_q;

    always_comb begin
        ctrl.feat_a64       = feat_a64_i;
        ctrl.feat_fgt       = feat_fgt_i;
        ctrl.lvl2_en        = lvl2_en_i;
        ctrl.has_lvl3       = has_lvl3_i;
        ctrl.halted         = halted_i;
        ctrl.ign_trap       = ign_trap_i;
        ctrl.l3_undef_prio  = l3_undef_prio_i;
        ctrl.l3_sec_dbg_dis = l3_sec_dbg_dis_i;
        ctrl.l3_comm        = l3_comm_trap_i;
        ctrl.l3_dbg         = l3_dbg_trap_i;
        ctrl.l2_comm        = l2_comm_trap_i;
        ctrl.l2_dbg         = l2_dbg_trap_i;
        ctrl.l2_gen         = l2_gen_trap_i;
        ctrl.l1_comm        = l1_comm_trap_i;
    end

    dcsr_trap_resolver u_resolver (
        .el_i  (cur_el_i),
        .ctrl_i(ctrl),
        .dec_o (dec)
    );

    assign is_read = req_i && (dec.kind == OUT_READ);

    dcsr_value_builder #(
        .DATA_W(DATA_W),
        .RX_POS(RX_POS),
        .TX_POS(TX_POS)
    ) u_value (
        .rx_full_i(rx_full_i),
        .tx_full_i(tx_full_i),
        .enable_i (is_read),
        .value_o  (value)
    );

    always_comb begin
        out_d         = '0;
        out_d.valid   = req_i;
        out_d.read_ok = is_read;
        out_d.undef   = req_i && (dec.kind == OUT_UNDEF);
        out_d.trap    = req_i && (dec.kind == OUT_TRAP);
        out_d.data    = value;
        if (out_d.trap) begin
            out_d.lvl = dec.lvl;
            out_d.ec  = EC_CODE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o    = out_q.valid;
    assign read_ok_o  = out_q.read_ok;
    assign undef_o    = out_q.undef;
    assign trap_o     = out_q.trap;
    assign trap_lvl_o = out_q.lvl;
    assign trap_ec_o  = out_q.ec;
    assign rdata_o    = out_q.data;
endmodule

// File: rtl/dcsr_access_checker.sv
module dcsr_access_checker #(
    parameter int DATA_W = 64,
    parameter int RX_POS = 30,
    parameter int TX_POS = 29,
    parameter int EC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [1:0]        cur_el_i,
    input logic              feat_a64_i,
    input logic              valid_o,
    input logic              read_ok_o,
    input logic              undef_o,
    input logic              trap_o,
    input logic [1:0]        trap_lvl_o,
    input logic [EC_W-1:0]   trap_ec_o,
    input logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << RX_POS) | (DATA_W'(1) << TX_POS);

    // R1
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!valid_o && !read_ok_o && !undef_o && !trap_o && rdata_o == '0));

    // R2
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));

    // R3
    a_r3_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $countones({read_ok_o, undef_o, trap_o}) == 1);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !(read_ok_o || undef_o || trap_o));

    // R4
    a_r4_data_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~FLAG_MASK) == '0 && (read_ok_o || rdata_o == '0));

    // R5
    a_r5_no_a64_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(rst_n) && !$past(feat_a64_i)) |-> undef_o);

    // R7
    a_r7_top_level_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(feat_a64_i) && $past(cur_el_i) == 2'd3) |-> read_ok_o);

    // R13
    a_r13_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_ec_o == EC_W'(6'h18) && trap_lvl_o != 2'd0));

    a_r13_no_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (trap_ec_o == '0 && trap_lvl_o == 2'd0));
endmodule

bind dcsr_access_resolver dcsr_access_checker #(
    .DATA_W(DATA_W),
    .RX_POS(RX_POS),
    .TX_POS(TX_POS),
    .EC_W  (EC_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cur_el_i  (cur_el_i),
    .feat_a64_i(feat_a64_i),
    .valid_o   (valid_o),
    .read_ok_o (read_ok_o),
    .undef_o   (undef_o),
    .trap_o    (trap_o),
    .trap_lvl_o(trap_lvl_o),
    .trap_ec_o (trap_ec_o),
    .rdata_o   (rdata_o)
);

// File: tb/dcsr_access_resolver_bench.sv
module dcsr_access_resolver_bench;

    // expected kind: 0 read, 1 undef, 2 trap
    typedef struct packed {
        logic [3:0] tag;
        logic [1:0] el;
        logic a64, fgt, l2en, has3, halt, ign, prio, sdd, l3c, l3d, l2c;
        logic [1:0] l2d;
        logic tge, l1c, rx, tx;
        logic [1:0] kind;
        logic [1:0] lvl;
    } vec_t;

    localparam int NV = 24;
    //                  tag  el    a64 fgt l2 h3 hlt ign pri sdd l3c l3d l2c l2d  tge l1c rx tx kind lvl
    localparam vec_t VECS [NV] = '{
        '{4'd5,  2'd0, 0,1,1,1, 0,0, 0,0, 0,0,0, 2'b00, 0,0, 1,1, 2'd1, 2'd0}, // R5
        '{4'd5,  2'd3, 0,1,1,1, 1,1, 0,0, 0,0,0, 2'b00, 0,0, 1,0, 2'd1, 2'd0}, // R5 beats halt
        '{4'd6,  2'd0, 1,1,1,1, 1,1, 1,0, 1,1,1, 2'b11, 1,1, 1,0, 2'd0, 2'd0}, // R6
        '{4'd6,  2'd1, 1,0,0,1, 1,0, 0,0, 0,1,0, 2'b00, 0,0, 0,0, 2'd2, 2'd3}, // R6 option off
        '{4'd7,  2'd3, 1,1,1,1, 0,0, 1,1, 1,1,1, 2'b11, 1,1, 0,1, 2'd0, 2'd0}, // R7
        '{4'd8,  2'd0, 1,1,1,1, 0,0, 1,0, 1,0,0, 2'b00, 1,1, 0,0, 2'd1, 2'd0}, // R8 over l1
        '{4'd8,  2'd2, 1,0,0,1, 0,0, 1,0, 0,1,0, 2'b00, 0,0, 0,0, 2'd1, 2'd0}, // R8 dbg bit
        '{4'd12, 2'd1, 1,0,0,1, 0,0, 1,0, 1,0,0, 2'b00, 0,0, 1,1, 2'd0, 2'd0}, // R12 no fgt
        '{4'd9,  2'd0, 1,1,1,0, 0,0, 0,0, 0,0,0, 2'b00, 1,1, 0,0, 2'd2, 2'd2}, // R9 to 2
        '{4'd9,  2'd0, 1,1,0,0, 0,0, 0,0, 0,0,0, 2'b00, 1,1, 0,0, 2'd2, 2'd1}, // R9 l2 off
        '{4'd9,  2'd0, 1,1,1,0, 0,0, 0,0, 0,0,0, 2'b11, 0,1, 0,0, 2'd2, 2'd1}, // R9 before l2
        '{4'd10, 2'd1, 1,1,1,0, 0,0, 0,0, 0,0,1, 2'b00, 0,0, 0,0, 2'd2, 2'd2}, // R10 comm
        '{4'd10, 2'd1, 1,0,1,0, 0,0, 0,0, 0,0,0, 2'b01, 0,0, 0,0, 2'd2, 2'd2}, // R10 dbg
        '{4'd10, 2'd0, 1,0,1,0, 0,0, 0,0, 0,0,0, 2'b10, 0,0, 0,0, 2'd2, 2'd2}, // R10 dbg hi
        '{4'd10, 2'd0, 1,0,1,0, 0,0, 0,0, 0,0,0, 2'b00, 1,0, 0,0, 2'd2, 2'd2}, // R10 gen lvl0
        '{4'd10, 2'd1, 1,1,0,0, 0,0, 0,0, 0,0,1, 2'b11, 1,0, 1,0, 2'd0, 2'd0}, // R10 l2 off
        '{4'd10, 2'd1, 1,0,1,0, 0,0, 0,0, 0,0,0, 2'b00, 1,0, 0,1, 2'd0, 2'd0}, // R10 gen lvl1
        '{4'd10, 2'd2, 1,1,1,0, 0,0, 0,0, 0,0,1, 2'b11, 1,0, 1,1, 2'd0, 2'd0}, // R10 lvl2
        '{4'd11, 2'd2, 1,1,0,1, 0,0, 0,0, 1,0,0, 2'b00, 0,0, 0,0, 2'd2, 2'd3}, // R11 trap
        '{4'd11, 2'd2, 1,1,0,1, 0,0, 0,1, 1,0,0, 2'b00, 0,0, 0,0, 2'd1, 2'd0}, // R11 undef
        '{4'd11, 2'd0, 1,0,0,1, 0,0, 0,0, 0,1,0, 2'b00, 0,0, 0,0, 2'd2, 2'd3}, // R11 lvl0
        '{4'd11, 2'd1, 1,0,1,1, 0,0, 0,0, 0,1,0, 2'b01, 0,0, 0,0, 2'd2, 2'd2}, // R11 after l2
        '{4'd12, 2'd1, 1,1,1,0, 0,0, 1,0, 1,1,0, 2'b00, 0,0, 0,0, 2'd0, 2'd0}, // R12 no lvl3
        '{4'd12, 2'd0, 1,0,1,0, 0,0, 0,0, 0,0,1, 2'b00, 0,1, 1,1, 2'd0, 2'd0}  // R12 no fgt
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    vec_t        cur = '0;
    logic        valid, read_ok, undef, trap;
    logic [1:0]  tlvl;
    logic [5:0]  tec;
    logic [63:0] rdata;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dcsr_access_resolver u_dcsr_access_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cur_el_i(cur.el),
        .feat_a64_i(cur.a64), .feat_fgt_i(cur.fgt), .lvl2_en_i(cur.l2en),
        .has_lvl3_i(cur.has3), .halted_i(cur.halt), .ign_trap_i(cur.ign),
        .l3_undef_prio_i(cur.prio), .l3_sec_dbg_dis_i(cur.sdd),
        .l3_comm_trap_i(cur.l3c), .l3_dbg_trap_i(cur.l3d),
        .l2_comm_trap_i(cur.l2c), .l2_dbg_trap_i(cur.l2d),
        .l2_gen_trap_i(cur.tge), .l1_comm_trap_i(cur.l1c),
        .rx_full_i(cur.rx), .tx_full_i(cur.tx),
        .valid_o(valid), .read_ok_o(read_ok), .undef_o(undef), .trap_o(trap),
        .trap_lvl_o(tlvl), .trap_ec_o(tec), .rdata_o(rdata)
    );

    task automatic check(input string req_name, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req_name, act, exp);
        end
    endtask

    function automatic logic [79:0] pack_out();
        return {6'd0, valid, read_ok, undef, trap, tlvl, tec, rdata};
    endfunction

    function automatic logic [79:0] expect_out(input vec_t v);
        logic [63:0] d;
        logic rd, un, tr;
        rd = (v.kind == 2'd0);
        un = (v.kind == 2'd1);
        tr = (v.kind == 2'd2);
        d  = rd ? ((64'(v.rx) << 30) | (64'(v.tx) << 29)) : 64'd0;
        return {6'd0, 1'b1, rd, un, tr, tr ? v.lvl : 2'd0, tr ? 6'h18 : 6'd0, d};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with a request held high
        req = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", pack_out(), 80'd0);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", pack_out(), 80'd0);

        // R2: idle produces nothing
        repeat (2) @(negedge clk);
        check("R2 idle", pack_out(), 80'd0);

        // table walk: R3..R13
        for (int i = 0; i < NV; i++) begin
            cur = VECS[i];
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            check($sformatf("R%0d vec %0d (R3 R4 R13)", VECS[i].tag, i), pack_out(), expect_out(VECS[i]));
            @(negedge clk);
            check($sformatf("R2 pulse ends vec %0d", i), {76'd0, valid, read_ok, undef, trap}, 80'd0);
        end

        // R2: back-to-back requests give back-to-back pulses
        cur = VECS[4];
        req = 1'b1;
        @(negedge clk);
        check("R2 b2b first", pack_out(), expect_out(VECS[4]));
        cur = VECS[8];
        @(negedge clk);
        req = 1'b0;
        check("R2 b2b second", pack_out(), expect_out(VECS[8]));
        @(negedge clk);
        check("R2 b2b end", {79'd0, valid}, 80'd0);

        // R4: flags change with no request do not reach rdata
        cur = VECS[4];
        cur.rx = 1'b1;
        cur.tx = 1'b1;
        @(negedge clk);
        check("R4 no read no data", {16'd0, rdata}, 80'd0);

        // R1: reset in the middle of a pending result
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", pack_out(), 80'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule